// File: doc/BRIEF.md
# Modulo-3 Running-Sum Accumulator

This block keeps a running total of 2-bit operands, reduced modulo 3. On every rising clock edge it adds the operand on its input to the stored total. It divides the result by three and stores the remainder as the new total. The stored total drives the output directly, so the output depends on state alone and the block behaves as a Moore machine.

The total is encoded as 00 for zero, 01 for one and 10 for two. Code 11 never occurs in normal operation. Operand value 11 is outside the legal input range: the caller must never drive it, and the block gives no defined result for it.

The next state comes from three two-level sum-of-products terms per state bit. These equations treat the unused code and the illegal operand as don't-cares.

Reset is asynchronous and active low. Its release passes through a short synchroniser, so accumulation begins a fixed number of edges after reset goes away.

Top module: `mod3_accum`

## Requirements
- R1: While `rst_n` is low, `sum_o` reads 00 immediately, without waiting for a clock edge.
- R2: With the default two synchroniser stages, the operand is ignored on the first two rising edges after `rst_n` rises. The first addition happens on the third edge.
- R3: Total zero is encoded as 00, one as 01 and two as 10. `sum_o` always equals the stored code.
- R4: On each rising edge outside reset, the new total is (old total + operand) mod 3, for operands 0, 1 and 2.
- R5: An operand of 00 leaves the total unchanged.
- R6: A total of 2 plus an operand of 2 gives a total of 1 (10 + 10 becomes 01).
- R7: While only legal operands are applied, `sum_o` never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| op_i | input | 2 | Operand to add this cycle (0, 1 or 2) |
| sum_o | output | 2 | Stored running total, modulo 3 |

## Verification
Any fault in the stored code or in a next-state term appears on `sum_o` one edge after the operand that exercises it. This is because the output is the state register itself. A term that is wrong for only one operand/state pair stays hidden until that exact pair occurs. The bench therefore walks every legal state and operand combination, then runs a long random stream against a modulo-3 model. A fault in the reset-release path shifts the first addition by whole edges, so the bench checks the total on each of the first three edges after release.

// File: rtl/mod3_accum_pkg.sv
package mod3_accum_pkg;
  localparam int SUM_W = 2;
  typedef logic [SUM_W-1:0] sum_t;
  localparam sum_t CODE_ZERO = 2'b00;
  localparam sum_t CODE_ONE  = 2'b01;
  localparam sum_t CODE_TWO  = 2'b10;
  localparam sum_t CODE_VOID = 2'b11;
endpackage

// File: rtl/mod3_rst_sync.sv
module mod3_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = stage_q[STAGES-1];

  // R1
  sync_assert_chk: assert property (@(posedge clk) !rst_n |-> !rst_sync_n);
endmodule

// File: rtl/mod3_next_state.sv
module mod3_next_state
  import mod3_accum_pkg::*;
(
  input  sum_t cur_i,
  input  sum_t op_i,
  output sum_t nxt_o
);
  logic y1, y0, x1, x0;

  always_comb begin
    y1 = cur_i[1];
    y0 = cur_i[0];
    x1 = op_i[1];
    x0 = op_i[0];
    nxt_o[1] = (y1 & ~x1 & ~x0) | (y0 & x0) | (~y1 & ~y0 & x1);
    nxt_o[0] = (y0 & ~x1 & ~x0) | (y1 & x1) | (~y1 & ~y0 & x0);
  end
endmodule

// File: rtl/mod3_state_reg.sv
module mod3_state_reg
  import mod3_accum_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sum_t d_i,
  output sum_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= CODE_ZERO;
    else        q_o <= d_i;
  end

  // R1
  reg_clear_chk: assert property (@(posedge clk) !rst_n |-> q_o == CODE_ZERO);
endmodule

// File: rtl/mod3_accum.sv
module mod3_accum
  import mod3_accum_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] op_i,
  output logic [1:0] sum_o
);
  logic rst_sync_n;
  sum_t state_q;
  sum_t state_d;

  mod3_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  mod3_next_state u_next (
    .cur_i (state_q),
    .op_i  (op_i),
    .nxt_o (state_d)
  );

  mod3_state_reg u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (state_d),
    .q_o   (state_q)
  );

  assign sum_o = state_q;

  // R4
  mod_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i != CODE_VOID && sum_o != CODE_VOID) |=>
      ({1'b0, sum_o} == (({1'b0, $past(sum_o)} + {1'b0, $past(op_i)}) % 3'd3)));

  // R5
  hold_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i == CODE_ZERO) |=> $stable(sum_o));

  // R7
  no_void_code_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_i != CODE_VOID && sum_o != CODE_VOID) |=> sum_o != CODE_VOID);

  // R2
  release_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> sum_o == CODE_ZERO);
endmodule

// File: tb/mod3_accum_tb.sv
`timescale 1ns/1ps
module mod3_accum_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] op_i;
  logic [1:0] sum_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned model = 0;
  bit          done  = 1'b0;

  always #2 clk = ~clk;

  mod3_accum u_dut (.clk(clk), .rst_n(rst_n), .op_i(op_i), .sum_o(sum_o));

  task automatic check(input string req, input logic [1:0] exp);
    n_vec++;
    if (sum_o !== exp) begin
      n_bad++;
      $display("FAIL %s: sum_o=%b expected=%b at %0t", req, sum_o, exp, $time);
    end
  endtask

  task automatic step(input logic [1:0] op);
    op_i = op;
    @(posedge clk);
    @(negedge clk);
    model = (model + op) % 3;
  endtask

  task automatic t_reset_and_release();
    @(negedge clk);
    rst_n = 1'b0; op_i = 2'd1;
    #1 check("R1", 2'b00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1; model = 0;
    @(posedge clk); @(negedge clk); check("R2", 2'b00);
    @(posedge clk); @(negedge clk); check("R2", 2'b00);
    step(2'd1); check("R2", 2'b01);
  endtask

  task automatic t_mid_cycle_reset();
    step(2'd1); check("R4", 2'b10);
    #1 rst_n = 1'b0;
    #0.5 check("R1", 2'b00);
    @(negedge clk);
    rst_n = 1'b1; model = 0; op_i = 2'd0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_encoding();
    step(2'd0); check("R3", 2'b00);
    step(2'd1); check("R3", 2'b01);
    step(2'd1); check("R3", 2'b10);
    step(2'd1); check("R3", 2'b00);
  endtask

  task automatic t_hold();
    step(2'd2); check("R5", 2'b10);
    step(2'd0); check("R5", 2'b10);
    step(2'd0); check("R5", 2'b10);
  endtask

  task automatic t_worked_case();
    if (model != 2) step(2'(model == 0 ? 2 : 1));
    step(2'd2); check("R6", 2'b01);
  endtask

  task automatic t_all_pairs();
    for (int s = 0; s < 3; s++) begin
      for (int o = 0; o < 3; o++) begin
        while (model != s) step(2'd1);
        step(2'(o));
        check("R4", 2'(model));
      end
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 400; i++) begin
      step(2'($urandom % 3));
      check("R4", 2'(model));
      if (sum_o === 2'b11) check("R7", 2'b00);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op_i  = 2'd0;
    #1 check("R1", 2'b00);
    repeat (2) @(negedge clk);
    t_reset_and_release();
    t_mid_cycle_reset();
    t_encoding();
    t_hold();
    t_worked_case();
    t_all_pairs();
    t_random();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule